// File: doc/BRIEF.md
# Divided-Clock Idle Wake Controller

This block controls the low-power idle mode of a processor core. A one-cycle idle request puts the core to sleep in one of two ways. The plain mode keeps the core clock enable high on every system clock cycle. The divided mode gates the core clock enable down to one strobe in every n system cycles. The divisor n is chosen by a 2-bit code from the set 16, 32, 64 and 128.

A vector of interrupt requests is qualified by a vector of per-line enable bits. In plain idle, any enabled request ends idle on the next cycle. In divided idle, an enabled request is held in a pending latch and acted on only at the next slow-clock strobe. Wake-up latency therefore depends on where the request falls in the slow period, and it is never more than n system cycles. The end of idle is marked by a one-cycle wake pulse, after which the core clock enable returns to always-on.

Top module: `iwc_top`

## Requirements
- R1: After reset the outputs are core_ce=1, idle_flag=0 and wake_pulse=0. Whenever the block is not idle (idle_flag=0), core_ce is 1.
- R2: An idle_req sampled while running sets idle_flag in the next cycle, which is idle cycle 0. With idle_plain=1, core_ce stays 1 in every idle cycle before the wake cycle.
- R3: In plain idle, an enabled request present in idle cycle t gives wake_pulse=1 in cycle t+1.
- R4: With idle_plain=0 the divisor is n = 16, 32, 64 or 128 for idle_div = 0, 1, 2 or 3. The divider restarts on idle entry, so core_ce is 1 exactly in idle cycles n-1, 2n-1, 3n-1 and so on, and 0 in all other idle cycles.
- R5: In divided idle, an enabled request present in idle cycle t causes wake_pulse in the cycle after the first core_ce strobe at or after t. The latency is therefore at most n cycles.
- R6: A request whose bit in irq_en is 0 does not end idle, and the core_ce strobes continue unchanged.
- R7: In divided idle, a request lasting a single cycle between strobes is latched and still causes the wake described in R5.
- R8: wake_pulse lasts exactly one cycle. During that cycle idle_flag=1 and core_ce=0. In the following cycle idle_flag=0 and core_ce=1.
- R9: An idle_req while idle_flag=1 is ignored: the divisor and the strobe timing are kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System (full-rate) clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| idle_req | input | 1 | Idle command strobe |
| idle_plain | input | 1 | 1: plain idle, 0: divided idle |
| idle_div | input | 2 | Divisor code: 0=16, 1=32, 2=64, 3=128 |
| irq | input | NUM_IRQ | Interrupt request lines |
| irq_en | input | NUM_IRQ | Per-line enable (1 = may wake) |
| core_ce | output | 1 | Core clock enable |
| idle_flag | output | 1 | Idle status |
| wake_pulse | output | 1 | One-cycle end-of-idle pulse |

## Verification
The critical coincidence is an enabled request that arrives in the same cycle as a slow-clock strobe. In that cycle the pending latch is loading while the strobe decides whether to wake. The bench provokes it by placing a one-cycle request exactly at idle cycle n-1, and also one cycle after a strobe. It judges both cases by the cycle in which wake_pulse appears: cycle n in the first case and cycle 2n in the second, with the core_ce pattern checked in every idle cycle.

// File: rtl/iwc_pkg.sv
package iwc_pkg;
  typedef enum logic [1:0] {
    ST_RUN  = 2'd0,
    ST_IDLE = 2'd1,
    ST_WAKE = 2'd2
  } iwc_state_e;
endpackage

// File: rtl/iwc_divider.sv
module iwc_divider #(
  parameter int BASE_LOG2 = 4,
  parameter int CODE_W    = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              restart,
  input  logic              run,
  input  logic [CODE_W-1:0] code,
  output logic              tick
);
  localparam int NUM_CODES = 1 << CODE_W;
  localparam int CNT_W     = BASE_LOG2 + NUM_CODES - 1;

  logic [CNT_W-1:0] lim_tab [NUM_CODES];
  logic [CNT_W-1:0] limit;
  logic [CNT_W-1:0] cnt_q, cnt_d;

  for (genvar g = 0; g < NUM_CODES; g++) begin : g_lim
    assign lim_tab[g] = CNT_W'((1 << (BASE_LOG2 + g)) - 1);
  end

  assign limit = lim_tab[code];
  assign tick  = run && (cnt_q == limit);

  always_comb begin
    cnt_d = cnt_q;
    if (restart)   cnt_d = '0;
    else if (run)  cnt_d = tick ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/iwc_irq_latch.sv
module iwc_irq_latch #(
  parameter int NUM_IRQ = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               clear,
  input  logic [NUM_IRQ-1:0] irq,
  input  logic [NUM_IRQ-1:0] irq_en,
  output logic               hit_now,
  output logic               pend_q
);
  logic pend_d;

  assign hit_now = |(irq & irq_en);

  always_comb begin
    pend_d = pend_q;
    if (clear)        pend_d = 1'b0;
    else if (hit_now) pend_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= 1'b0;
    else        pend_q <= pend_d;
  end
endmodule

// File: rtl/iwc_fsm.sv
module iwc_fsm
  import iwc_pkg::*;
#(
  parameter int CODE_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              idle_req,
  input  logic              idle_plain,
  input  logic [CODE_W-1:0] idle_div,
  input  logic              tick,
  input  logic              hit_now,
  input  logic              pend_q,
  output logic              entry,
  output logic              div_run,
  output logic              lat_clear,
  output logic [CODE_W-1:0] code_q,
  output logic              core_ce,
  output logic              idle_flag,
  output logic              wake_pulse
);
  iwc_state_e        state_q, state_d;
  logic              plain_q, plain_d;
  logic [CODE_W-1:0] code_d;
  logic              wake_now;

  assign entry     = (state_q == ST_RUN) && idle_req;
  assign div_run   = (state_q == ST_IDLE) && !plain_q;
  assign lat_clear = (state_q != ST_IDLE);
  assign wake_now  = plain_q ? (hit_now || pend_q) : (tick && (hit_now || pend_q));

  always_comb begin
    state_d = state_q;
    plain_d = plain_q;
    code_d  = code_q;
    case (state_q)
      ST_RUN: if (idle_req) begin
        state_d = ST_IDLE;
        plain_d = idle_plain;
        code_d  = idle_div;
      end
      ST_IDLE: if (wake_now) state_d = ST_WAKE;
      ST_WAKE: state_d = ST_RUN;
      default: state_d = ST_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_RUN;
      plain_q <= 1'b1;
      code_q  <= '0;
    end else begin
      state_q <= state_d;
      plain_q <= plain_d;
      code_q  <= code_d;
    end
  end

  assign core_ce    = (state_q == ST_RUN) || ((state_q == ST_IDLE) && (plain_q || tick));
  assign idle_flag  = (state_q != ST_RUN);
  assign wake_pulse = (state_q == ST_WAKE);
endmodule

// File: rtl/iwc_top.sv
module iwc_top #(
  parameter int NUM_IRQ   = 4,
  parameter int BASE_LOG2 = 4,
  parameter int CODE_W    = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               idle_req,
  input  logic               idle_plain,
  input  logic [CODE_W-1:0]  idle_div,
  input  logic [NUM_IRQ-1:0] irq,
  input  logic [NUM_IRQ-1:0] irq_en,
  output logic               core_ce,
  output logic               idle_flag,
  output logic               wake_pulse
);
  logic [1:0]        rst_sync_q;
  logic              rst_core_n;
  logic              tick, hit_now, pend_q, entry, div_run, lat_clear;
  logic [CODE_W-1:0] code_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_core_n = rst_sync_q[1];

  iwc_fsm #(.CODE_W(CODE_W)) u_fsm (
    .clk(clk), .rst_n(rst_core_n), .idle_req(idle_req), .idle_plain(idle_plain),
    .idle_div(idle_div), .tick(tick), .hit_now(hit_now), .pend_q(pend_q),
    .entry(entry), .div_run(div_run), .lat_clear(lat_clear), .code_q(code_q),
    .core_ce(core_ce), .idle_flag(idle_flag), .wake_pulse(wake_pulse)
  );

  iwc_divider #(.BASE_LOG2(BASE_LOG2), .CODE_W(CODE_W)) u_div (
    .clk(clk), .rst_n(rst_core_n), .restart(entry), .run(div_run),
    .code(code_q), .tick(tick)
  );

  iwc_irq_latch #(.NUM_IRQ(NUM_IRQ)) u_lat (
    .clk(clk), .rst_n(rst_core_n), .clear(lat_clear), .irq(irq),
    .irq_en(irq_en), .hit_now(hit_now), .pend_q(pend_q)
  );
endmodule

// File: rtl/iwc_checker.sv
module iwc_checker #(
  parameter int MAX_DIV = 128
) (
  input logic clk,
  input logic rst_n,
  input logic idle_req,
  input logic core_ce,
  input logic idle_flag,
  input logic wake_pulse
);
  logic [8:0] gap_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       gap_q <= '0;
    else if (core_ce) gap_q <= '0;
    else if (gap_q != 9'h1ff) gap_q <= gap_q + 1'b1;
  end

  // R1
  run_ce_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !idle_flag |-> core_ce);

  // R2
  idle_entry_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(idle_flag) |-> $past(idle_req));

  // R8
  wake_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wake_pulse |=> (!wake_pulse && core_ce && !idle_flag));

  // R8
  wake_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wake_pulse |-> (idle_flag && !core_ce));

  // R5
  strobe_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    gap_q < 9'(MAX_DIV));
endmodule

bind iwc_top iwc_checker #(.MAX_DIV(1 << (BASE_LOG2 + (1 << CODE_W) - 1))) u_iwc_chk (
  .clk(clk), .rst_n(rst_n), .idle_req(idle_req), .core_ce(core_ce),
  .idle_flag(idle_flag), .wake_pulse(wake_pulse)
);

// File: tb/iwc_top_test.sv
module iwc_top_test;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 8;

  typedef struct packed {
    logic        plain;
    logic [1:0]  code;
    logic [12:0] k;
    logic [15:0] w;
  } vec_t;

  // plain/code, request cycle k, expected wake cycle w (idle cycle 0 = first idle_flag cycle)
  localparam vec_t VECS [NV] = '{
    '{1'b1, 2'd0, 13'd3,   16'd4},
    '{1'b0, 2'd0, 13'd0,   16'd16},
    '{1'b0, 2'd0, 13'd15,  16'd16},
    '{1'b0, 2'd0, 13'd16,  16'd32},
    '{1'b0, 2'd1, 13'd5,   16'd32},
    '{1'b0, 2'd2, 13'd63,  16'd64},
    '{1'b0, 2'd3, 13'd0,   16'd128},
    '{1'b0, 2'd3, 13'd130, 16'd256}
  };

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       idle_req = 1'b0;
  logic       idle_plain = 1'b0;
  logic [1:0] idle_div = 2'd0;
  logic [3:0] irq = 4'd0;
  logic [3:0] irq_en = 4'hf;
  logic       core_ce, idle_flag, wake_pulse;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  iwc_top uut (
    .clk(clk), .rst_n(rst_n), .idle_req(idle_req), .idle_plain(idle_plain),
    .idle_div(idle_div), .irq(irq), .irq_en(irq_en), .core_ce(core_ce),
    .idle_flag(idle_flag), .wake_pulse(wake_pulse)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic enter_idle(input logic plain, input logic [1:0] code);
    @(negedge clk);
    idle_req = 1'b1; idle_plain = plain; idle_div = code;
    @(negedge clk);
    idle_req = 1'b0;
  endtask

  task automatic end_idle();
    irq[0] = 1'b1;
    for (int i = 0; i < 300 && !wake_pulse; i++) @(negedge clk);
    irq[0] = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R1 reset state
    check(core_ce == 1'b1, "R1 core_ce", core_ce, 1);
    check(idle_flag == 1'b0, "R1 idle_flag", idle_flag, 0);
    check(wake_pulse == 1'b0, "R1 wake_pulse", wake_pulse, 0);

    // table walk: R2 R3 R4 R5 R7 R8
    for (int v = 0; v < NV; v++) begin
      int n, wseen, bad, w, k;
      n = 16 << VECS[v].code;
      w = int'(VECS[v].w);
      k = int'(VECS[v].k);
      wseen = -1; bad = 0;
      enter_idle(VECS[v].plain, VECS[v].code);
      for (int t = 0; t <= w; t++) begin
        logic exp_ce;
        exp_ce = (t == w) ? 1'b0 : (VECS[v].plain ? 1'b1 : (((t + 1) % n) == 0));
        if (core_ce !== exp_ce || idle_flag !== 1'b1) bad++;
        if (wake_pulse === 1'b1 && wseen < 0) wseen = t;
        irq[1] = (t == k);
        @(negedge clk);
      end
      check(bad == 0, VECS[v].plain ? "R2 R3 idle ce pattern" : "R4 strobe pattern", bad, 0);
      check(wseen == w, VECS[v].plain ? "R3 plain wake cycle" : "R5 R7 divided wake cycle", wseen, w);
      check(core_ce && !idle_flag && !wake_pulse, "R8 after wake", {core_ce, idle_flag, wake_pulse}, 4);
      @(negedge clk);
    end

    // R6 masked request ignored
    irq_en = 4'b0001;
    enter_idle(1'b0, 2'd0);
    begin
      int bad;
      bad = 0;
      irq[2] = 1'b1;
      for (int t = 0; t < 40; t++) begin
        if (wake_pulse || !idle_flag || core_ce !== (((t + 1) % 16) == 0)) bad++;
        @(negedge clk);
      end
      irq[2] = 1'b0;
      check(bad == 0, "R6 masked request", bad, 0);
    end
    end_idle();
    check(!idle_flag && core_ce, "R6 enabled line wakes", idle_flag, 0);
    irq_en = 4'hf;

    // R9 idle_req while idle ignored
    enter_idle(1'b0, 2'd0);
    begin
      int bad;
      bad = 0;
      for (int t = 0; t < 48; t++) begin
        if (core_ce !== (((t + 1) % 16) == 0) || !idle_flag) bad++;
        idle_req = (t == 5 || t == 20); idle_div = 2'd3; idle_plain = (t == 20);
        @(negedge clk);
      end
      idle_req = 1'b0;
      check(bad == 0, "R9 request while idle ignored", bad, 0);
    end
    end_idle();
    check(!idle_flag, "R9 exit", idle_flag, 0);

    // R8 wake pulse width in plain mode
    enter_idle(1'b1, 2'd2);
    irq[3] = 1'b1;
    @(negedge clk);
    irq[3] = 1'b0;
    check(wake_pulse && idle_flag && !core_ce, "R8 wake cycle", {wake_pulse, idle_flag, core_ce}, 6);
    @(negedge clk);
    check(!wake_pulse && !idle_flag && core_ce, "R8 pulse width", {wake_pulse, idle_flag, core_ce}, 1);

    // R1 reset while idle
    enter_idle(1'b0, 2'd1);
    rst_n = 1'b0;
    @(negedge clk);
    check(core_ce && !idle_flag && !wake_pulse, "R1 reset in idle", {core_ce, idle_flag, wake_pulse}, 4);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule